// File: doc/BRIEF.md
# SIMD Lane Reshaper

This block rearranges the lanes of 64-bit packed operands. It does one of three things. It can interleave lanes from one half of A with the matching lanes from the same half of B. It can widen the lanes of one half of A to twice their size, using zero or sign extension. It can narrow the lanes of both A and B to half their size by truncation, and concatenate the results. The result and a 32-bit lane status word are captured in one register stage.

The status word holds a negative flag and a zero flag for every lane of the result. The flags are always computed at the width of the result lane. Each result lane of W bits owns W/2 bits of the status word. Its top bit is N and the bit below it is Z. Every other status bit is zero.

A pipeline feeds one operation per cycle by raising `in_valid` together with the operands and the controls. The result appears on the next cycle with `out_valid`.

Top module: `simd_lane_reshaper`

## Requirements
- R1: While `rst` is high at a clock edge, the following edge leaves `out_valid`, `res` and `flags` all at zero.
- R2: `out_valid` is high exactly one cycle after a cycle in which `in_valid` was high, and is low otherwise. `res` and `flags` load only on valid cycles and otherwise keep their last value, whatever the other inputs do.
- R3: With `op`=0 (interleave) and lane size L, lane k of the selected half of A goes to result lane 2k, and lane k of the selected half of B goes to result lane 2k+1. The result lane size is L.
- R4: For interleave and widen, `hi_sel`=0 takes source lanes from bits 31..0 of the operands, and `hi_sel`=1 takes them from bits 63..32.
- R5: With `op`=1 (zero widen), each lane of size L in the selected half of A becomes a result lane of size 2L whose upper L bits are zero.
- R6: With `op`=2 (sign widen), the upper L bits of each result lane are copies of bit L-1 of the source lane.
- R7: With `op`=3 (narrow), `lane_sz` gives the result lane size L. Each 2L-bit lane of A keeps its low L bits and fills bits 31..0 in lane order. Each 2L-bit lane of B does the same for bits 63..32. `hi_sel` has no effect.
- R8: For 8-bit result lanes, lane i has N at status bit 4i+3 and Z at bit 4i+2, and bits 4i+1 and 4i are zero.
- R9: For 16-bit result lanes, lane h has N at bit 8h+7 and Z at bit 8h+6. For 32-bit lanes, lane w has N at 16w+15 and Z at 16w+14. For a 64-bit result, N is at bit 31 and Z at bit 30. All other status bits are zero.
- R10: N is the top bit of the result lane, and Z is set only when the whole result lane is zero. The flag width follows the result lane: widen uses 2L. The `lane_sz` encoding is 0=8, 1=16, 2=32, and 3 behaves as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 interleave, 1 zero widen, 2 sign widen, 3 narrow |
| lane_sz | input | 2 | Lane size code: 0=8, 1=16, 2 or 3=32 |
| hi_sel | input | 1 | Source half for interleave and widen |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result valid |
| res | output | 64 | Registered result |
| flags | output | 32 | Registered per-lane N/Z status word |

## Verification
The bench drives lanes whose top bit is set, and lanes that are exactly zero, in both halves. A design that placed flags at the source lane width instead of the result width would put N and Z in the wrong nibbles after a widen. A design with a wrong half select or a swapped A/B order would scramble the interleaved bytes, and a missing sign fill would leave the high bits of negative widened lanes clear.

Narrow is driven with `hi_sel` set and with lane size code 3. A design that let `hi_sel` steer narrow, or that decoded code 3 as an 8-bit lane, would produce mismatched results. Idle cycles with changing operands show whether the output register loads without a strobe.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

    localparam int DATA_W  = 64;
    localparam int HALF_W  = DATA_W / 2;
    localparam int FLAG_W  = DATA_W / 2;
    localparam int N_SIZES = 3;   // 8, 16, 32-bit source/result lane choices
    localparam int N_FSIZE = 4;   // 8, 16, 32, 64-bit flag lane choices

    typedef enum logic [1:0] {
        OP_ILV    = 2'd0,
        OP_ZEXT   = 2'd1,
        OP_SEXT   = 2'd2,
        OP_NARROW = 2'd3
    } rsh_op_e;

    typedef logic [1:0] lane_code_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [FLAG_W-1:0] stat;
    } rsh_out_t;

    // Code 3 is folded onto the 32-bit lane size.
    function automatic lane_code_t clamp_sz(lane_code_t s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction

    // Lane width at which the result is flagged.
    function automatic lane_code_t result_code(rsh_op_e o, lane_code_t s);
        lane_code_t c;
        c = clamp_sz(s);
        if (o == OP_ZEXT || o == OP_SEXT)
            return c + 2'd1;
        return c;
    endfunction

endpackage

// File: rtl/rsh_interleave.sv
module rsh_interleave
    import rsh_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          hi,
    input  lane_code_t    sz,
    output logic [DW-1:0] y
);
    localparam int HW = DW / 2;

    logic [HW-1:0] a_half;
    logic [HW-1:0] b_half;
    logic [N_SIZES-1:0][DW-1:0] cand;

    assign a_half = hi ? a[DW-1:HW] : a[HW-1:0];
    assign b_half = hi ? b[DW-1:HW] : b[HW-1:0];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
        localparam int L  = 8 << g;
        localparam int NL = HW / L;
        for (genvar k = 0; k < NL; k++) begin : g_lane
            assign cand[g][2*k*L +: L]     = a_half[k*L +: L];
            assign cand[g][2*k*L + L +: L] = b_half[k*L +: L];
        end
    end

    assign y = cand[clamp_sz(sz)];

endmodule

// File: rtl/rsh_widen.sv
module rsh_widen
    import rsh_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic          hi,
    input  logic          sgn,
    input  lane_code_t    sz,
    output logic [DW-1:0] y
);
    localparam int HW = DW / 2;

    logic [HW-1:0] src;
    logic [N_SIZES-1:0][DW-1:0] cand;

    assign src = hi ? a[DW-1:HW] : a[HW-1:0];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
        localparam int L  = 8 << g;
        localparam int NL = HW / L;
        for (genvar k = 0; k < NL; k++) begin : g_lane
            assign cand[g][2*k*L +: 2*L] =
                {{L{sgn & src[k*L + L - 1]}}, src[k*L +: L]};
        end
    end

    assign y = cand[clamp_sz(sz)];

endmodule

// File: rtl/rsh_narrow.sv
module rsh_narrow
    import rsh_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  lane_code_t    sz,
    output logic [DW-1:0] y
);
    localparam int HW = DW / 2;

    logic [N_SIZES-1:0][DW-1:0] cand;

    for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
        localparam int L  = 8 << g;   // result lane width
        localparam int NL = HW / L;   // lanes per operand
        for (genvar k = 0; k < NL; k++) begin : g_lane
            assign cand[g][k*L +: L]      = a[2*k*L +: L];
            assign cand[g][HW + k*L +: L] = b[2*k*L +: L];
        end
    end

    assign y = cand[clamp_sz(sz)];

endmodule

// File: rtl/rsh_flags.sv
module rsh_flags
    import rsh_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]   d,
    input  lane_code_t      code,
    output logic [DW/2-1:0] f
);
    localparam int FW = DW / 2;

    logic [N_FSIZE-1:0][FW-1:0] cand;

    for (genvar g = 0; g < N_FSIZE; g++) begin : g_sz
        localparam int W  = 8 << g;   // result lane width
        localparam int S  = W / 2;    // status bits owned by one lane
        localparam int NL = DW / W;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            assign cand[g][i*S + S - 1] = d[i*W + W - 1];
            assign cand[g][i*S + S - 2] = ~|d[i*W +: W];
            assign cand[g][i*S +: S-2]  = '0;
        end
    end

    assign f = cand[code];

endmodule

// File: rtl/simd_lane_reshaper.sv
module simd_lane_reshaper
    import rsh_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic [1:0]    lane_sz,
    input  logic          hi_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          out_valid,
    output logic [DW-1:0] res,
    output logic [DW/2-1:0] flags
);
    localparam int FW = DW / 2;
    localparam int HW = DW / 2;

    rsh_op_e       op_e;
    logic [DW-1:0] ilv_y;
    logic [DW-1:0] wid_y;
    logic [DW-1:0] nar_y;
    logic [DW-1:0] nxt_res;
    logic [FW-1:0] nxt_flags;
    lane_code_t    fcode;

    assign op_e  = rsh_op_e'(op);
    assign fcode = result_code(op_e, lane_sz);

    rsh_interleave #(.DW(DW)) u_ilv (
        .a (opa), .b (opb), .hi (hi_sel), .sz (lane_sz), .y (ilv_y)
    );

    rsh_widen #(.DW(DW)) u_wid (
        .a (opa), .hi (hi_sel), .sgn (op_e == OP_SEXT), .sz (lane_sz), .y (wid_y)
    );

    rsh_narrow #(.DW(DW)) u_nar (
        .a (opa), .b (opb), .sz (lane_sz), .y (nar_y)
    );

    always_comb begin
        case (op_e)
            OP_ILV:           nxt_res = ilv_y;
            OP_ZEXT, OP_SEXT: nxt_res = wid_y;
            default:          nxt_res = nar_y;
        endcase
    end

    rsh_flags #(.DW(DW)) u_flg (
        .d (nxt_res), .code (fcode), .f (nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '0;
            flags     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res   <= nxt_res;
                flags <= nxt_flags;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && res == '0 && flags == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res) && $stable(flags))); // R2

    AST_NARROW_LANE0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3) |=>
            (res[7:0] == $past(opa[7:0]) && res[HW+7:HW] == $past(opb[7:0]))); // R7

    AST_LOW_PAIR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((flags & {(FW/4){4'b0011}}) == '0)); // R8

    AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((flags >> 1) & flags & {(FW/4){4'b0100}}) == '0)); // R10

endmodule

// File: tb/sim_simd_lane_reshaper.sv
module sim_simd_lane_reshaper;
    import rsh_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [1:0]  lane_sz;
    logic        hi_sel;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_valid;
    logic [63:0] res;
    logic [31:0] flags;

    always #10 clk = ~clk;   // 50 MHz

    simd_lane_reshaper u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
        .hi_sel(hi_sel), .opa(opa), .opb(opb), .out_valid(out_valid),
        .res(res), .flags(flags)
    );

    typedef struct {
        logic [63:0] r;
        logic [31:0] f;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    exp_t last_exp;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input logic [1:0] o, input logic [1:0] s,
                                  input logic h, input logic [63:0] a,
                                  input logic [63:0] b,
                                  output logic [63:0] r, output logic [31:0] f);
        int L, W, S;
        logic [31:0] ah, bh;
        logic z;
        L  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        ah = h ? a[63:32] : a[31:0];
        bh = h ? b[63:32] : b[31:0];
        r  = '0;
        f  = '0;
        W  = L;
        if (o == 2'd0) begin
            for (int k = 0; k < 32 / L; k++)
                for (int j = 0; j < L; j++) begin
                    r[2*k*L + j]     = ah[k*L + j];
                    r[2*k*L + L + j] = bh[k*L + j];
                end
        end else if (o == 2'd3) begin
            for (int k = 0; k < 32 / L; k++)
                for (int j = 0; j < L; j++) begin
                    r[k*L + j]      = a[2*k*L + j];
                    r[32 + k*L + j] = b[2*k*L + j];
                end
        end else begin
            W = 2 * L;
            for (int k = 0; k < 32 / L; k++)
                for (int j = 0; j < 2 * L; j++)
                    r[2*k*L + j] = (j < L) ? ah[k*L + j]
                                 : ((o == 2'd2) ? ah[k*L + L - 1] : 1'b0);
        end
        S = W / 2;
        for (int i = 0; i < 64 / W; i++) begin
            z = 1'b1;
            for (int j = 0; j < W; j++)
                if (r[i*W + j]) z = 1'b0;
            f[i*S + S - 1] = r[i*W + W - 1];
            f[i*S + S - 2] = z;
        end
    endfunction

    task automatic send(input logic [1:0] o, input logic [1:0] s, input logic h,
                        input logic [63:0] a, input logic [63:0] b,
                        input string tag);
        exp_t e;
        @(negedge clk);
        op = o; lane_sz = s; hi_sel = h; opa = a; opb = b; in_valid = 1'b1;
        model(o, s, h, a, b, e.r, e.f);
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = {$urandom, $urandom};
            opb = {$urandom, $urandom};
            op = 2'($urandom);
        end
    endtask

    // Monitor: pop and compare as results emerge.
    always @(posedge clk) begin
        #5;
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R2 unexpected out_valid", {32'd0, res}, 96'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                last_exp = e;
                chk({res, flags} == {e.r, e.f}, e.tag, {res, flags}, {e.r, e.f});
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] mr;
        logic [31:0] mf;
        rst = 1'b1; in_valid = 1'b0; op = '0; lane_sz = '0; hi_sel = 1'b0;
        opa = 64'hFFFF_FFFF_FFFF_FFFF; opb = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(posedge clk);
        #5;
        chk(!out_valid && res == '0 && flags == '0, "R1 reset state",
            {31'd0, out_valid, res}, 96'd0);
        @(negedge clk);
        rst = 1'b0;

        // Hand-computed anchors for the model.
        model(2'd0, 2'd0, 1'b0, 64'h0706050403020100, 64'h1716151413121110, mr, mf);
        chk(mr == 64'h1303_1202_1101_1000, "R3 byte interleave order", {32'd0, mr},
            {32'd0, 64'h1303_1202_1101_1000});
        model(2'd3, 2'd0, 1'b1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, mr, mf);
        chk({mr, mf} == {64'hAABBCCDD_11223344, 32'h8888_0000}, "R7 R8 narrow bytes",
            {mr, mf}, {64'hAABBCCDD_11223344, 32'h8888_0000});
        model(2'd2, 2'd1, 1'b1, 64'h8001_7FFF_0000_0000, 64'd0, mr, mf);
        chk({mr, mf} == {64'hFFFF8001_00007FFF, 32'h8000_0000}, "R6 R9 sign widen half",
            {mr, mf}, {64'hFFFF8001_00007FFF, 32'h8000_0000});
        model(2'd1, 2'd2, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'd0, mr, mf);
        chk({mr, mf} == {64'd0, 32'h4000_0000}, "R5 R9 zero widen word zero",
            {mr, mf}, {64'd0, 32'h4000_0000});

        // Directed traffic through the design.
        send(2'd0, 2'd0, 1'b0, 64'h0706050403020100, 64'h1716151413121110, "R3 ilv byte lo");
        send(2'd0, 2'd0, 1'b1, 64'h80FF_0001_1234_5678, 64'h0000_8000_9ABC_DEF0, "R4 ilv byte hi");
        send(2'd0, 2'd1, 1'b1, 64'h8000_0000_1111_2222, 64'h0001_FFFF_3333_4444, "R4 R9 ilv half hi");
        send(2'd0, 2'd2, 1'b0, 64'h5555_5555_8000_0000, 64'h6666_6666_0000_0000, "R9 ilv word lo");
        send(2'd1, 2'd0, 1'b0, 64'h0102_0304_80FF_0011, 64'hFFFF_FFFF_FFFF_FFFF, "R5 zext byte lo");
        send(2'd2, 2'd0, 1'b1, 64'h80FF_007F_0000_0000, 64'd0, "R6 sext byte hi");
        send(2'd2, 2'd1, 1'b1, 64'h8001_7FFF_0000_0000, 64'd0, "R6 sext half hi");
        send(2'd2, 2'd2, 1'b0, 64'h0000_0000_8000_0000, 64'd0, "R6 R9 sext word 64-bit flags");
        send(2'd1, 2'd2, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'd0, "R5 R9 zext word zero");
        send(2'd3, 2'd0, 1'b1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, "R7 narrow byte hi_sel ignored");
        send(2'd3, 2'd1, 1'b0, 64'hFFFF_0000_0001_8000, 64'h0000_0000_0000_0000, "R7 R8 narrow half");
        send(2'd3, 2'd3, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R10 narrow code3");
        send(2'd0, 2'd3, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h8000_0001_0000_0000, "R10 ilv code3");
        send(2'd0, 2'd0, 1'b0, 64'd0, 64'd0, "R8 all zero byte lanes");
        idle(4);
        #15;
        chk(!out_valid && res == last_exp.r && flags == last_exp.f, "R2 hold when idle",
            {31'd0, out_valid, res}, {32'd0, last_exp.r});

        // Random mix, back to back with gaps.
        for (int n = 0; n < 400; n++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) ra[15:0] = 16'h0000;
            if ($urandom_range(0, 3) == 0) rb[63:48] = 16'h0000;
            send(2'($urandom), 2'($urandom), 1'($urandom), ra, rb, "R10 random");
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(4);
        #15;
        chk(sbq.size() == 0, "R2 scoreboard drained", 96'(sbq.size()), 96'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule